// File: doc/BRIEF.md
# Interrupt Request Flag Register Bank

This block collects one-cycle event pulses from on-chip peripherals and external interrupt lines into sticky request flags. The sources are a timer-A counter wrap, serial channel 1, five external interrupt lines, a timer-FL source that covers compare match and overflow, and a timer-Y overflow. A flag stays set until software clears it by writing a 0 to its bit. Software can never set a flag, and accepting the interrupt does not clear it. Each flag is gated by an enable: some enables are held in a local enable register, and the others (serial channel and external lines) come in on input pins. Any flag whose enable is also 1 drives the single combined request line.

The CPU side is a plain synchronous port with an address, a write strobe and write data, and a combinational read-data output. Three registers are mapped. Address 0 is the main flag register. Address 1 is the enable register. Address 2 is the timer flag register. Address 3 is unmapped.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset the main flag register reads 0x20, the timer flag register reads 0xF9, the enable register reads 0x79, and irq_out is 0.
- R2: A pulse on an event input sets its flag on the next rising clock edge. In the main flag register the bits are: bit 7 timer-A wrap, bit 6 serial channel 1, bits 4..0 external lines 4..0. In the timer flag register the bits are: bit 2 timer-FL, bit 1 timer-Y.
- R3: A write to a flag register clears every flag whose data bit is 0. A data bit of 1 leaves its flag unchanged and never sets it.
- R4: A set flag stays set through any number of cycles without a clearing write.
- R5: When an event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R6: Reserved bits always read as 1 and ignore writes. These are main flag bit 5, timer flag bits 7..3 and bit 0, and enable bits 6..3 and bit 0.
- R7: Enable bits are read/write: bit 7 enables timer-A, bit 2 enables timer-FL, and bit 1 enables timer-Y.
- R8: irq_out is 1 exactly when some flag is 1 and its enable is 1. For serial channel 1 the enable is ext_en[5], and for external line n it is ext_en[n]. Reserved bits never raise irq_out.
- R9: A write to address 3 changes no register, and a read from address 3 returns 0xFF.
- R10: cpu_rdata shows, in the same cycle, the register selected by cpu_addr: 0 is main flags, 1 is enables, 2 is timer flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tmra_wrap | input | 1 | Timer-A wrap pulse |
| ev_ser1 | input | 1 | Serial channel 1 request pulse |
| ev_ext | input | 5 | External interrupt line pulses, lines 4..0 |
| ev_tmrfl | input | 1 | Timer-FL compare match or overflow pulse |
| ev_tmry | input | 1 | Timer-Y overflow pulse |
| ext_en | input | 6 | External enables: bit 5 serial, bits 4..0 external lines |
| cpu_addr | input | ADDR_W | Register address |
| cpu_we | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for cpu_addr |
| req_main_q | output | 8 | Main flag register contents |
| req_tmr_q | output | 8 | Timer flag register contents |
| ena_q | output | 8 | Enable register contents |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clearing write that lands on a flag in the same cycle as that flag's own event pulse, because the write and the pulse come from unrelated agents. The vector table drives both in one cycle, writing 0x00 to the main flags while pulsing external line 2. It then checks that only that flag survives. Writes of all ones to both the flag and enable registers show that software cannot set a flag and that reserved bits stay at 1.

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_tmra_wrap,
  input  logic              ev_ser1,
  input  logic [4:0]        ev_ext,
  input  logic              ev_tmrfl,
  input  logic              ev_tmry,
  input  logic [5:0]        ext_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic [7:0]        req_main_q,
  output logic [7:0]        req_tmr_q,
  output logic [7:0]        ena_q,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] A_MAIN = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TMR  = ADDR_W'(2);
  localparam logic [7:0] MAIN_RSV = 8'h20;
  localparam logic [7:0] TMR_RSV  = 8'hF9;
  localparam logic [7:0] ENA_RSV  = 8'h79;

  logic [7:0] main_r, tmr_r, ena_r;
  logic [7:0] main_set, tmr_set, main_gate;
  logic       wr_main, wr_tmr, wr_ena;

  assign main_set  = {ev_tmra_wrap, ev_ser1, 1'b0, ev_ext};
  assign tmr_set   = {5'b0, ev_tmrfl, ev_tmry, 1'b0};
  assign wr_main   = cpu_we && (cpu_addr == A_MAIN);
  assign wr_tmr    = cpu_we && (cpu_addr == A_TMR);
  assign wr_ena    = cpu_we && (cpu_addr == A_ENA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_r <= 8'h00;
      tmr_r  <= 8'h00;
      ena_r  <= 8'h00;
    end else begin
      main_r <= ((main_r & (wr_main ? cpu_wdata : 8'hFF)) | main_set) & ~MAIN_RSV;
      tmr_r  <= ((tmr_r & (wr_tmr ? cpu_wdata : 8'hFF)) | tmr_set) & ~TMR_RSV;
      if (wr_ena) ena_r <= cpu_wdata & ~ENA_RSV;
    end
  end

  assign req_main_q = main_r | MAIN_RSV;
  assign req_tmr_q  = tmr_r | TMR_RSV;
  assign ena_q      = ena_r | ENA_RSV;

  assign main_gate = {ena_r[7], ext_en[5], 1'b0, ext_en[4:0]};
  assign irq_out   = (|(main_r & main_gate)) | (|(tmr_r & ena_r & ~TMR_RSV));

  always_comb begin
    case (cpu_addr)
      A_MAIN:  cpu_rdata = req_main_q;
      A_ENA:   cpu_rdata = ena_q;
      A_TMR:   cpu_rdata = req_tmr_q;
      default: cpu_rdata = 8'hFF;
    endcase
  end
endmodule

// File: rtl/irq_flag_bank_chk.sv
module irq_flag_bank_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_tmra_wrap,
  input logic              ev_ser1,
  input logic [4:0]        ev_ext,
  input logic              ev_tmrfl,
  input logic              ev_tmry,
  input logic [5:0]        ext_en,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_we,
  input logic [7:0]        cpu_wdata,
  input logic [7:0]        req_main_q,
  input logic [7:0]        req_tmr_q,
  input logic [7:0]        ena_q,
  input logic              irq_out
);
  logic       live;
  logic [7:0] s_main, s_tmr;
  logic       any_ev;

  assign s_main = {ev_tmra_wrap, ev_ser1, 1'b0, ev_ext};
  assign s_tmr  = {5'b0, ev_tmrfl, ev_tmry, 1'b0};
  assign any_ev = |{s_main, s_tmr};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  // R3
  main_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    ((req_main_q & ~$past(req_main_q)) & ~$past(s_main)) == 8'h00);

  // R4
  main_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    ((~req_main_q & $past(req_main_q)) &
     ~(($past(cpu_we) && $past(cpu_addr) == ADDR_W'(0)) ? ~$past(cpu_wdata) : 8'h00)) == 8'h00);

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    ((req_main_q & $past(s_main)) == $past(s_main)) &&
    ((req_tmr_q & $past(s_tmr)) == $past(s_tmr)));

  // R6
  reserved_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_main_q[5] && (req_tmr_q[7:3] == 5'h1F) && req_tmr_q[0] &&
    (ena_q[6:3] == 4'hF) && ena_q[0]);

  // R7
  ena_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (cpu_we && cpu_addr == ADDR_W'(1)) |=> (ena_q == ($past(cpu_wdata) | 8'h79)));

  // R8
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_main_q == 8'h20 && req_tmr_q == 8'hF9) |-> !irq_out);

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (cpu_we && cpu_addr == ADDR_W'(3) && !any_ev) |=>
    ($stable(req_main_q) && $stable(req_tmr_q) && $stable(ena_q)));
endmodule

bind irq_flag_bank irq_flag_bank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_irq_flag_bank.sv
module tb_irq_flag_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_tmra_wrap, ev_ser1, ev_tmrfl, ev_tmry;
  logic [4:0] ev_ext;
  logic [5:0] ext_en;
  logic [1:0] cpu_addr;
  logic       cpu_we;
  logic [7:0] cpu_wdata, cpu_rdata, req_main_q, req_tmr_q, ena_q;
  logic       irq_out;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  irq_flag_bank #(.ADDR_W(2)) dut (.*);

  typedef struct packed {
    logic [1:0] addr;
    logic       we;
    logic [7:0] wd;
    logic [8:0] ev;
    logic [5:0] xen;
    logic [7:0] e_main;
    logic [7:0] e_tmr;
    logic [7:0] e_ena;
    logic       e_irq;
  } vec_t;

  // ev bits: {tmra, ser1, ext[4:0], tmrfl, tmry}
  localparam vec_t TBL [14] = '{
    '{2'd0, 1'b0, 8'h00, 9'h100, 6'h00, 8'hA0, 8'hF9, 8'h79, 1'b0},
    '{2'd1, 1'b1, 8'h80, 9'h000, 6'h00, 8'hA0, 8'hF9, 8'hF9, 1'b1},
    '{2'd0, 1'b1, 8'hFF, 9'h000, 6'h00, 8'hA0, 8'hF9, 8'hF9, 1'b1},
    '{2'd0, 1'b1, 8'h7F, 9'h000, 6'h00, 8'h20, 8'hF9, 8'hF9, 1'b0},
    '{2'd0, 1'b0, 8'h00, 9'h054, 6'h00, 8'h35, 8'hF9, 8'hF9, 1'b0},
    '{2'd0, 1'b0, 8'h00, 9'h000, 6'h01, 8'h35, 8'hF9, 8'hF9, 1'b1},
    '{2'd0, 1'b0, 8'h00, 9'h003, 6'h00, 8'h35, 8'hFF, 8'hF9, 1'b0},
    '{2'd1, 1'b1, 8'h04, 9'h000, 6'h00, 8'h35, 8'hFF, 8'h7D, 1'b1},
    '{2'd2, 1'b1, 8'hFB, 9'h080, 6'h00, 8'h75, 8'hFB, 8'h7D, 1'b0},
    '{2'd0, 1'b1, 8'h00, 9'h010, 6'h00, 8'h24, 8'hFB, 8'h7D, 1'b0},
    '{2'd3, 1'b1, 8'h00, 9'h000, 6'h04, 8'h24, 8'hFB, 8'h7D, 1'b1},
    '{2'd1, 1'b1, 8'h00, 9'h000, 6'h00, 8'h24, 8'hFB, 8'h79, 1'b0},
    '{2'd2, 1'b1, 8'h00, 9'h000, 6'h00, 8'h24, 8'hF9, 8'h79, 1'b0},
    '{2'd1, 1'b1, 8'h06, 9'h001, 6'h00, 8'h24, 8'hFB, 8'h7F, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] a, input logic w, input logic [7:0] d,
                       input logic [8:0] ev, input logic [5:0] x);
    cpu_addr = a; cpu_we = w; cpu_wdata = d; ext_en = x;
    {ev_tmra_wrap, ev_ser1, ev_ext, ev_tmrfl, ev_tmry} = ev;
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    drive(2'd0, 1'b0, 8'h00, 9'h000, 6'h00);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #0.5;
    // R1 reset values
    chk("R1 main", req_main_q, 8'h20);
    chk("R1 tmr", req_tmr_q, 8'hF9);
    chk("R1 ena", ena_q, 8'h79);
    chk("R1 irq", {7'b0, irq_out}, 8'h00);
    // R9 unmapped read
    cpu_addr = 2'd3; #0.5;
    chk("R9 read", cpu_rdata, 8'hFF);

    // R2 R3 R4 R5 R7 R8 R9 table
    foreach (TBL[i]) begin
      @(negedge clk);
      drive(TBL[i].addr, TBL[i].we, TBL[i].wd, TBL[i].ev, TBL[i].xen);
      step();
      chk($sformatf("R2/R3/R5 main v%0d", i), req_main_q, TBL[i].e_main);
      chk($sformatf("R2/R3 tmr v%0d", i), req_tmr_q, TBL[i].e_tmr);
      chk($sformatf("R7/R9 ena v%0d", i), ena_q, TBL[i].e_ena);
      chk($sformatf("R8 irq v%0d", i), {7'b0, irq_out}, {7'b0, TBL[i].e_irq});
    end

    // R4 sticky over idle cycles
    @(negedge clk); drive(2'd0, 1'b0, 8'h00, 9'h000, 6'h00);
    repeat (5) @(posedge clk); #1;
    chk("R4 hold main", req_main_q, 8'h24);
    chk("R4 hold tmr", req_tmr_q, 8'hFB);

    // R10 read mux
    @(negedge clk);
    cpu_addr = 2'd0; #0.5; chk("R10 rd main", cpu_rdata, 8'h24);
    cpu_addr = 2'd1; #0.5; chk("R10 rd ena", cpu_rdata, 8'h7F);
    cpu_addr = 2'd2; #0.5; chk("R10 rd tmr", cpu_rdata, 8'hFB);

    // R6 reserved bits ignore writes of 0
    @(negedge clk); drive(2'd1, 1'b1, 8'h00, 9'h000, 6'h00); step();
    chk("R6 ena rsv", ena_q, 8'h79);
    @(negedge clk); drive(2'd1, 1'b1, 8'hFF, 9'h000, 6'h00); step();
    chk("R6 ena all ones", ena_q, 8'hFF);
    @(negedge clk); drive(2'd0, 1'b1, 8'h00, 9'h000, 6'h00); step();
    chk("R6 main rsv", req_main_q, 8'h20);
    @(negedge clk); drive(2'd2, 1'b1, 8'h00, 9'h000, 6'h00); step();
    chk("R6 tmr rsv", req_tmr_q, 8'hF9);
    // R8 reserved bits with all enables do not raise irq
    chk("R8 rsv no irq", {7'b0, irq_out}, 8'h00);

    // R8 serial flag gated by ext_en[5]
    @(negedge clk); drive(2'd0, 1'b0, 8'h00, 9'h080, 6'h00); step();
    chk("R8 ser gated off", {7'b0, irq_out}, 8'h00);
    @(negedge clk); drive(2'd0, 1'b0, 8'h00, 9'h000, 6'h20); #0.5;
    chk("R8 ser gated on", {7'b0, irq_out}, 8'h01);

    // R5 set wins on timer register
    @(negedge clk); drive(2'd2, 1'b1, 8'h00, 9'h001, 6'h00); step();
    chk("R5 tmr set wins", req_tmr_q, 8'hFB);

    @(negedge clk); drive(2'd0, 1'b0, 8'h00, 9'h000, 6'h00);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule